// File: doc/BRIEF.md
# CPU Low-Power Mode and Setpoint Controller

This block follows the low-power state of one CPU and arbitrates the requests that move the whole system to a new performance setpoint. The CPU sits in one of four modes: run, wait, stop or suspend. Software programs the mode to enter on the next sleep event. The block moves its mode state machine there when the CPU signals wait-for-interrupt, or wait-for-event if that is enabled. A wakeup request returns the CPU to run.

A setpoint change can come from three sources: a software request, a request armed for the next sleep, and a request armed for the next wakeup. Each request is tested against a 16-bit allowed-setpoint mask that belongs to the CPU mode concerned. An allowed request is handed to the downstream power sequencer. It completes when the sequencer returns a one-cycle done pulse. A refused request leaves the setpoint alone and sets a sticky status bit for its source. Any enabled status bit drives the interrupt line. A small word-addressed register port holds all configuration and status. Its reads are combinational and its writes take effect on the next clock edge.

Top module: `cpu_pm_ctrl`

## Requirements
- R1: After reset the mode is run (code 0) with previous mode run, current, previous and target setpoints are 0, every allowed mask reads 0xFFFF, interrupt enables and status are 0, seq_req is low and irq is low.
- R2: Mode codes are run=0, wait=1, stop=2, suspend=3. The mode-config word (address 0) holds the target mode in bits [1:0] and the WFE enable in bit 4. While in run with no setpoint transition busy, a high wfi moves cpu_mode to a non-run target one cycle later. The mode-status word (address 1) then reads the new mode in [1:0] and run in [3:2]. A target of run leaves the CPU in run.
- R3: A wfe pulse is a sleep event only when the WFE enable bit is 1. Otherwise the mode does not change.
- R4: In a non-run mode, wake_req with no transition busy returns cpu_mode to run one cycle later. Mode status [3:2] then holds the mode that was left.
- R5: The request word (address 2) holds the software go bit in bit 0 and its setpoint in [7:4]. If the setpoint is allowed by the current mode's mask, seq_req rises with seq_sp equal to that setpoint. Both hold until done, and the go bit reads 1 until done.
- R6: A seq_done pulse while seq_req is high makes current = requested and previous = old current, drops seq_req and clears the software go bit. A seq_done pulse while seq_req is low has no effect.
- R7: A software setpoint outside the current mode's mask sets status bit 18 and clears the go bit on the next edge. The setpoint status and seq_req do not change.
- R8: Request bit 8 arms a sleep request with its setpoint in [15:12]. The sleep event consumes it (bit 8 clears). The setpoint is checked against the mask of the mode being entered. A refusal sets status bit 16.
- R9: Request bit 16 arms a wakeup request with its setpoint in [23:20]. Select bit 24 chooses that setpoint when 1, or the setpoint that was current when the last sleep began when 0. The result is checked against the run mask. A refusal sets status bit 17.
- R10: The interrupt word (address 4) holds the enables in [2:0] (sleep, wakeup, software) and the status bits in [18:16]. A status bit stays set until 1 is written to it. irq is high exactly when some status bit and its enable are both set.
- R11: Allowed masks are at addresses 8+mode, bits [15:0]. Writing 1 to bit 0 of the lock word (address 5) makes the masks read-only, and the lock stays set until reset.
- R12: While seq_req is high, sleep and wakeup events are held off and cpu_mode does not change. A held sleep event is taken in the cycle after the transition ends.
- R13: The setpoint-status word (address 3) reads the current setpoint in [3:0], the previous in [7:4] and the last requested target in [11:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| wfi | input | 1 | CPU wait-for-interrupt indication |
| wfe | input | 1 | CPU wait-for-event indication |
| wake_req | input | 1 | Wakeup request |
| seq_done | input | 1 | One-cycle completion pulse from the power sequencer |
| seq_req | output | 1 | Setpoint transition in progress |
| seq_sp | output | 4 | Setpoint requested from the sequencer |
| cpu_mode | output | 2 | Current CPU mode |
| irq | output | 1 | Not-allowed interrupt |

## Verification
The bench builds the block with its default widths: 16 setpoints, four modes and a 4-bit register address. With these values every mask bit position and every address, including the four mask words, can be reached by direct stimulus. A behavioural model tracks mode, setpoints, request fields and status and is compared on every clock. Directed sequences cover each refusal source and the saved-setpoint wakeup path. They also cover a sleep event held behind a busy transition and mask writes after the lock is set.

// File: rtl/cpu_pm_pkg.sv
package cpu_pm_pkg;

    localparam int REG_W     = 32;
    localparam int NUM_SP    = 16;
    localparam int SP_W      = $clog2(NUM_SP);
    localparam int NUM_MODES = 4;
    localparam int NUM_SRC   = 3;

    typedef enum logic [1:0] {
        MODE_RUN     = 2'd0,
        MODE_WAIT    = 2'd1,
        MODE_STOP    = 2'd2,
        MODE_SUSPEND = 2'd3
    } cpu_mode_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_SLEEP = 2'd1,
        SRC_WAKE  = 2'd2,
        SRC_SW    = 2'd3
    } sp_src_e;

    typedef logic [SP_W-1:0]   sp_t;
    typedef logic [NUM_SP-1:0] sp_mask_t;

    typedef struct packed {
        logic sw_go;
        sp_t  sw_sp;
        logic sleep_go;
        sp_t  sleep_sp;
        logic wake_go;
        sp_t  wake_sp;
        logic wake_sel;
    } sp_req_t;

    // status / enable bit index per refused source
    localparam int IRQ_SLEEP    = 0;
    localparam int IRQ_WAKE     = 1;
    localparam int IRQ_SW       = 2;
    localparam int IRQ_STAT_LSB = 16;

    // request word layout
    localparam int SW_GO_BIT    = 0;
    localparam int SW_SP_LSB    = 4;
    localparam int SLEEP_GO_BIT = 8;
    localparam int SLEEP_SP_LSB = 12;
    localparam int WAKE_GO_BIT  = 16;
    localparam int WAKE_SP_LSB  = 20;
    localparam int WAKE_SEL_BIT = 24;

    // word addresses
    localparam int ADDR_MODE_CFG  = 0;
    localparam int ADDR_MODE_STAT = 1;
    localparam int ADDR_SP_REQ    = 2;
    localparam int ADDR_SP_STAT   = 3;
    localparam int ADDR_IRQ       = 4;
    localparam int ADDR_LOCK      = 5;
    localparam int ADDR_MAP_BASE  = 8;

    function automatic sp_req_t unpack_req(input logic [REG_W-1:0] w);
        sp_req_t r;
        r.sw_go    = w[SW_GO_BIT];
        r.sw_sp    = w[SW_SP_LSB +: SP_W];
        r.sleep_go = w[SLEEP_GO_BIT];
        r.sleep_sp = w[SLEEP_SP_LSB +: SP_W];
        r.wake_go  = w[WAKE_GO_BIT];
        r.wake_sp  = w[WAKE_SP_LSB +: SP_W];
        r.wake_sel = w[WAKE_SEL_BIT];
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pack_req(input sp_req_t r);
        logic [REG_W-1:0] w;
        w = '0;
        w[SW_GO_BIT]              = r.sw_go;
        w[SW_SP_LSB +: SP_W]      = r.sw_sp;
        w[SLEEP_GO_BIT]           = r.sleep_go;
        w[SLEEP_SP_LSB +: SP_W]   = r.sleep_sp;
        w[WAKE_GO_BIT]            = r.wake_go;
        w[WAKE_SP_LSB +: SP_W]    = r.wake_sp;
        w[WAKE_SEL_BIT]           = r.wake_sel;
        return w;
    endfunction

    function automatic logic sp_allowed(input sp_mask_t m, input sp_t s);
        return m[s];
    endfunction

endpackage

// File: rtl/cpu_pm_regs.sv
module cpu_pm_regs
    import cpu_pm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [REG_W-1:0]                  wdata,
    output logic [REG_W-1:0]                  rdata,
    output cpu_mode_e                         tgt_mode,
    output logic                              wfe_en,
    output sp_req_t                           req,
    output logic [NUM_MODES-1:0][NUM_SP-1:0]  masks,
    output logic [NUM_SRC-1:0]                irq_en,
    output logic [NUM_SRC-1:0]                irq_stat,
    output logic                              cfg_lock,
    input  cpu_mode_e                         cur_mode,
    input  cpu_mode_e                         prev_mode,
    input  sp_t                               sp_cur,
    input  sp_t                               sp_prev,
    input  sp_t                               sp_tgt,
    input  logic [NUM_SRC-1:0]                irq_set,
    input  logic                              sw_clr,
    input  logic                              sleep_take,
    input  logic                              wake_take
);

    localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(ADDR_MODE_CFG);
    localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'(ADDR_MODE_STAT);
    localparam logic [ADDR_W-1:0] A_REQ   = ADDR_W'(ADDR_SP_REQ);
    localparam logic [ADDR_W-1:0] A_SSTAT = ADDR_W'(ADDR_SP_STAT);
    localparam logic [ADDR_W-1:0] A_IRQ   = ADDR_W'(ADDR_IRQ);
    localparam logic [ADDR_W-1:0] A_LOCK  = ADDR_W'(ADDR_LOCK);

    sp_req_t            req_d;
    logic [NUM_SRC-1:0] stat_d;
    logic               unused_wdata;

    assign unused_wdata = ^wdata[REG_W-1:WAKE_SEL_BIT+1];

    always_comb begin
        req_d = req;
        if (wr && addr == A_REQ)
            req_d = unpack_req(wdata);
        if (sleep_take) req_d.sleep_go = 1'b0;
        if (wake_take)  req_d.wake_go  = 1'b0;
        if (sw_clr)     req_d.sw_go    = 1'b0;
    end

    always_comb begin
        stat_d = irq_stat;
        if (wr && addr == A_IRQ)
            stat_d = stat_d & ~wdata[IRQ_STAT_LSB +: NUM_SRC];
        stat_d = stat_d | irq_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_mode <= MODE_RUN;
            wfe_en   <= 1'b0;
            req      <= '0;
            irq_en   <= '0;
            irq_stat <= '0;
            cfg_lock <= 1'b0;
        end else begin
            if (wr && addr == A_CFG) begin
                tgt_mode <= cpu_mode_e'(wdata[1:0]);
                wfe_en   <= wdata[4];
            end
            if (wr && addr == A_IRQ)
                irq_en <= wdata[NUM_SRC-1:0];
            if (wr && addr == A_LOCK && wdata[0])
                cfg_lock <= 1'b1;
            req      <= req_d;
            irq_stat <= stat_d;
        end
    end

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mask
        localparam logic [ADDR_W-1:0] A_MAP = ADDR_W'(ADDR_MAP_BASE + m);
        sp_mask_t mask_q;
        always_ff @(posedge clk) begin
            if (rst)
                mask_q <= '1;
            else if (wr && addr == A_MAP && !cfg_lock)
                mask_q <= wdata[NUM_SP-1:0];
        end
        assign masks[m] = mask_q;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CFG: begin
                rdata[1:0] = tgt_mode;
                rdata[4]   = wfe_en;
            end
            A_MSTAT: begin
                rdata[1:0] = cur_mode;
                rdata[3:2] = prev_mode;
            end
            A_REQ:   rdata = pack_req(req);
            A_SSTAT: begin
                rdata[0 +: SP_W]      = sp_cur;
                rdata[4 +: SP_W]      = sp_prev;
                rdata[8 +: SP_W]      = sp_tgt;
            end
            A_IRQ: begin
                rdata[NUM_SRC-1:0]                = irq_en;
                rdata[IRQ_STAT_LSB +: NUM_SRC]    = irq_stat;
            end
            A_LOCK:  rdata[0] = cfg_lock;
            default: ;
        endcase
        for (int m = 0; m < NUM_MODES; m++) begin
            if (addr == ADDR_W'(ADDR_MAP_BASE + m))
                rdata[NUM_SP-1:0] = masks[m];
        end
    end

endmodule

// File: rtl/cpu_pm_mode_fsm.sv
module cpu_pm_mode_fsm
    import cpu_pm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cpu_mode_e tgt_mode,
    input  logic      wfe_en,
    input  logic      wfi,
    input  logic      wfe,
    input  logic      wake_req,
    input  logic      hold,
    output cpu_mode_e cur_mode,
    output cpu_mode_e prev_mode,
    output logic      sleep_evt,
    output logic      wake_evt
);

    logic sleep_cause;

    assign sleep_cause = wfi || (wfe && wfe_en);
    assign sleep_evt   = (cur_mode == MODE_RUN) && (tgt_mode != MODE_RUN)
                         && sleep_cause && !hold;
    assign wake_evt    = (cur_mode != MODE_RUN) && wake_req && !hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_mode  <= MODE_RUN;
            prev_mode <= MODE_RUN;
        end else if (sleep_evt) begin
            prev_mode <= cur_mode;
            cur_mode  <= tgt_mode;
        end else if (wake_evt) begin
            prev_mode <= cur_mode;
            cur_mode  <= MODE_RUN;
        end
    end

endmodule

// File: rtl/cpu_pm_sp_ctrl.sv
module cpu_pm_sp_ctrl
    import cpu_pm_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  sp_req_t                           req,
    input  logic [NUM_MODES-1:0][NUM_SP-1:0]  masks,
    input  cpu_mode_e                         cur_mode,
    input  cpu_mode_e                         tgt_mode,
    input  logic                              sleep_evt,
    input  logic                              wake_evt,
    input  logic                              seq_done,
    output sp_t                               sp_cur,
    output sp_t                               sp_prev,
    output sp_t                               sp_tgt,
    output logic                              busy,
    output logic [NUM_SRC-1:0]                irq_set,
    output logic                              sw_clr
);

    sp_src_e src_q;
    sp_t     saved_sp;
    logic    launch;
    sp_t     l_sp;
    sp_src_e l_src;
    sp_t     wake_pick;
    logic    finish;

    assign finish    = busy && seq_done;
    assign wake_pick = req.wake_sel ? req.wake_sp : saved_sp;

    always_comb begin
        launch  = 1'b0;
        l_sp    = '0;
        l_src   = SRC_NONE;
        irq_set = '0;
        sw_clr  = 1'b0;
        if (sleep_evt) begin
            if (req.sleep_go) begin
                if (sp_allowed(masks[tgt_mode], req.sleep_sp)) begin
                    launch = 1'b1;
                    l_sp   = req.sleep_sp;
                    l_src  = SRC_SLEEP;
                end else begin
                    irq_set[IRQ_SLEEP] = 1'b1;
                end
            end
        end else if (wake_evt) begin
            if (req.wake_go) begin
                if (sp_allowed(masks[MODE_RUN], wake_pick)) begin
                    launch = 1'b1;
                    l_sp   = wake_pick;
                    l_src  = SRC_WAKE;
                end else begin
                    irq_set[IRQ_WAKE] = 1'b1;
                end
            end
        end else if (req.sw_go && !busy) begin
            if (sp_allowed(masks[cur_mode], req.sw_sp)) begin
                launch = 1'b1;
                l_sp   = req.sw_sp;
                l_src  = SRC_SW;
            end else begin
                irq_set[IRQ_SW] = 1'b1;
                sw_clr          = 1'b1;
            end
        end
        if (finish && src_q == SRC_SW)
            sw_clr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_cur   <= '0;
            sp_prev  <= '0;
            sp_tgt   <= '0;
            saved_sp <= '0;
            busy     <= 1'b0;
            src_q    <= SRC_NONE;
        end else begin
            if (finish) begin
                sp_prev <= sp_cur;
                sp_cur  <= sp_tgt;
                busy    <= 1'b0;
                src_q   <= SRC_NONE;
            end
            if (launch) begin
                busy   <= 1'b1;
                sp_tgt <= l_sp;
                src_q  <= l_src;
            end
            if (sleep_evt)
                saved_sp <= sp_cur;
        end
    end

endmodule

// File: rtl/cpu_pm_ctrl.sv
module cpu_pm_ctrl
    import cpu_pm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              wfi,
    input  logic              wfe,
    input  logic              wake_req,
    input  logic              seq_done,
    output logic              seq_req,
    output logic [3:0]        seq_sp,
    output logic [1:0]        cpu_mode,
    output logic              irq
);

    cpu_mode_e                         tgt_mode_w;
    logic                              wfe_en_w;
    sp_req_t                           req_w;
    logic [NUM_MODES-1:0][NUM_SP-1:0]  masks_w;
    logic [NUM_SRC-1:0]                irq_en_w;
    logic [NUM_SRC-1:0]                irq_stat_w;
    logic                              cfg_lock_w;
    cpu_mode_e                         cur_mode_w;
    cpu_mode_e                         prev_mode_w;
    logic                              sleep_evt_w;
    logic                              wake_evt_w;
    sp_t                               sp_cur_w;
    sp_t                               sp_prev_w;
    sp_t                               sp_tgt_w;
    logic                              busy_w;
    logic [NUM_SRC-1:0]                irq_set_w;
    logic                              sw_clr_w;

    cpu_pm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .tgt_mode   (tgt_mode_w),
        .wfe_en     (wfe_en_w),
        .req        (req_w),
        .masks      (masks_w),
        .irq_en     (irq_en_w),
        .irq_stat   (irq_stat_w),
        .cfg_lock   (cfg_lock_w),
        .cur_mode   (cur_mode_w),
        .prev_mode  (prev_mode_w),
        .sp_cur     (sp_cur_w),
        .sp_prev    (sp_prev_w),
        .sp_tgt     (sp_tgt_w),
        .irq_set    (irq_set_w),
        .sw_clr     (sw_clr_w),
        .sleep_take (sleep_evt_w),
        .wake_take  (wake_evt_w)
    );

    cpu_pm_mode_fsm u_mode (
        .clk       (clk),
        .rst       (rst),
        .tgt_mode  (tgt_mode_w),
        .wfe_en    (wfe_en_w),
        .wfi       (wfi),
        .wfe       (wfe),
        .wake_req  (wake_req),
        .hold      (busy_w),
        .cur_mode  (cur_mode_w),
        .prev_mode (prev_mode_w),
        .sleep_evt (sleep_evt_w),
        .wake_evt  (wake_evt_w)
    );

    cpu_pm_sp_ctrl u_sp (
        .clk       (clk),
        .rst       (rst),
        .req       (req_w),
        .masks     (masks_w),
        .cur_mode  (cur_mode_w),
        .tgt_mode  (tgt_mode_w),
        .sleep_evt (sleep_evt_w),
        .wake_evt  (wake_evt_w),
        .seq_done  (seq_done),
        .sp_cur    (sp_cur_w),
        .sp_prev   (sp_prev_w),
        .sp_tgt    (sp_tgt_w),
        .busy      (busy_w),
        .irq_set   (irq_set_w),
        .sw_clr    (sw_clr_w)
    );

    assign seq_req  = busy_w;
    assign seq_sp   = sp_tgt_w;
    assign cpu_mode = cur_mode_w;
    assign irq      = |(irq_stat_w & irq_en_w);

endmodule

// File: rtl/cpu_pm_ctrl_chk.sv
module cpu_pm_ctrl_chk
    import cpu_pm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [31:0]        reg_wdata,
    input logic               wake_req,
    input logic               seq_done,
    input logic               seq_req,
    input logic [3:0]         seq_sp,
    input logic [1:0]         cpu_mode,
    input logic [1:0]         tgt_mode,
    input logic [3:0]         sp_cur,
    input logic [NUM_SRC-1:0] irq_stat,
    input logic               cfg_lock
);

    logic [NUM_SRC-1:0] kept;

    assign kept = irq_stat &
        ~((reg_wr && reg_addr == ADDR_W'(ADDR_IRQ)) ? reg_wdata[IRQ_STAT_LSB +: NUM_SRC] : '0);

    // R2: with a run target the CPU cannot leave run
    a_r2_run_target_stays: assert property (@(posedge clk) disable iff (rst)
        (cpu_mode == 2'd0 && tgt_mode == 2'd0) |=> cpu_mode == 2'd0);

    // R4: an unblocked wakeup returns to run
    a_r4_wake_to_run: assert property (@(posedge clk) disable iff (rst)
        (cpu_mode != 2'd0 && wake_req && !seq_req) |=> cpu_mode == 2'd0);

    // R5: the request to the sequencer is held steady until done
    a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
        (seq_req && !seq_done) |=> (seq_req && $stable(seq_sp)));

    // R6: done commits the requested setpoint
    a_r6_done_commits: assert property (@(posedge clk) disable iff (rst)
        (seq_req && seq_done) |=> (!seq_req && sp_cur == $past(seq_sp)));

    // R6, R7: the current setpoint moves only at completion
    a_r6_idle_no_change: assert property (@(posedge clk) disable iff (rst)
        !seq_req |=> $stable(sp_cur));

    // R10: status bits are sticky unless written with 1
    a_r10_status_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((irq_stat & $past(kept)) == $past(kept)));

    // R11: the lock never falls outside reset
    a_r11_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        cfg_lock |=> cfg_lock);

    // R12: mode frozen while a transition is busy
    a_r12_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        seq_req |=> $stable(cpu_mode));

endmodule

bind cpu_pm_ctrl cpu_pm_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .wake_req  (wake_req),
    .seq_done  (seq_done),
    .seq_req   (seq_req),
    .seq_sp    (seq_sp),
    .cpu_mode  (cpu_mode),
    .tgt_mode  (tgt_mode_w),
    .sp_cur    (sp_cur_w),
    .irq_stat  (irq_stat_w),
    .cfg_lock  (cfg_lock_w)
);

// File: tb/test_cpu_pm_ctrl.sv
`timescale 1ns/1ps
module test_cpu_pm_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wfi = 1'b0;
    logic        wfe = 1'b0;
    logic        wake_req = 1'b0;
    logic        seq_done = 1'b0;
    logic        seq_req;
    logic [3:0]  seq_sp;
    logic [1:0]  cpu_mode;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    cpu_pm_ctrl #(.ADDR_W(4)) i_cpu_pm_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wfi(wfi), .wfe(wfe),
        .wake_req(wake_req), .seq_done(seq_done), .seq_req(seq_req),
        .seq_sp(seq_sp), .cpu_mode(cpu_mode), .irq(irq)
    );

    // behavioural reference model
    int m_mode, m_mprev, m_tgt, m_wfe;
    int m_swgo, m_swsp, m_sgo, m_ssp, m_wgo, m_wsp, m_wsel;
    int m_en, m_stat, m_lock;
    int m_mask[4];
    int m_cur, m_pcur, m_target, m_busy, m_src, m_saved;

    function automatic int allowed(int mask, int sp);
        return (mask >> sp) & 1;
    endfunction

    always @(posedge clk) begin : model
        int set, lsp, lsrc, pick, launch, clr, se, we, was_busy;
        if (rst) begin
            m_mode = 0; m_mprev = 0; m_tgt = 0; m_wfe = 0;
            m_swgo = 0; m_swsp = 0; m_sgo = 0; m_ssp = 0; m_wgo = 0; m_wsp = 0; m_wsel = 0;
            m_en = 0; m_stat = 0; m_lock = 0;
            for (int i = 0; i < 4; i++) m_mask[i] = 'hFFFF;
            m_cur = 0; m_pcur = 0; m_target = 0; m_busy = 0; m_src = 0; m_saved = 0;
        end else begin
            was_busy = m_busy;
            se = (m_mode == 0 && m_tgt != 0 && (wfi || (wfe && m_wfe)) && !was_busy) ? 1 : 0;
            we = (m_mode != 0 && wake_req && !was_busy) ? 1 : 0;
            set = 0; launch = 0; lsp = 0; lsrc = 0; clr = 0;
            if (se) begin
                if (m_sgo) begin
                    if (allowed(m_mask[m_tgt], m_ssp)) begin launch = 1; lsp = m_ssp; lsrc = 1; end
                    else set |= 1;
                end
            end else if (we) begin
                if (m_wgo) begin
                    pick = m_wsel ? m_wsp : m_saved;
                    if (allowed(m_mask[0], pick)) begin launch = 1; lsp = pick; lsrc = 2; end
                    else set |= 2;
                end
            end else if (m_swgo && !was_busy) begin
                if (allowed(m_mask[m_mode], m_swsp)) begin launch = 1; lsp = m_swsp; lsrc = 3; end
                else begin set |= 4; clr = 1; end
            end
            if (was_busy && seq_done) begin
                if (m_src == 3) clr = 1;
                m_pcur = m_cur; m_cur = m_target; m_busy = 0; m_src = 0;
            end
            if (launch) begin m_busy = 1; m_target = lsp; m_src = lsrc; end
            if (se) begin m_saved = m_cur; m_mprev = 0; m_mode = m_tgt; end
            if (we) begin m_mprev = m_mode; m_mode = 0; end
            if (reg_wr) begin
                case (reg_addr)
                    0: begin m_tgt = reg_wdata[1:0]; m_wfe = reg_wdata[4]; end
                    2: begin
                        m_swgo = reg_wdata[0];  m_swsp = reg_wdata[7:4];
                        m_sgo  = reg_wdata[8];  m_ssp  = reg_wdata[15:12];
                        m_wgo  = reg_wdata[16]; m_wsp  = reg_wdata[23:20];
                        m_wsel = reg_wdata[24];
                    end
                    4: begin m_en = reg_wdata[2:0]; m_stat = m_stat & ~int'(reg_wdata[18:16]); end
                    5: if (reg_wdata[0]) m_lock = 1;
                    8, 9, 10, 11: if (!m_lock) m_mask[reg_addr - 8] = reg_wdata[15:0];
                    default: ;
                endcase
            end
            if (se) m_sgo = 0;
            if (we) m_wgo = 0;
            if (clr) m_swgo = 0;
            m_stat = m_stat | set;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !ended) begin
            chk("R2 R4 cpu_mode vs model", int'(cpu_mode), m_mode);
            chk("R5 seq_req vs model", int'(seq_req), m_busy);
            if (m_busy) chk("R5 seq_sp vs model", int'(seq_sp), m_target);
            chk("R10 irq vs model", int'(irq), ((m_stat & m_en) != 0) ? 1 : 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !ended) begin
            ended = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL R12 watchdog actual=%0d expected<100000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a[3:0]; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        @(negedge clk);
        reg_addr = a[3:0];
        #1;
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic pulse_wfi();  @(negedge clk); wfi = 1'b1;      @(negedge clk); wfi = 1'b0;      endtask
    task automatic pulse_wfe();  @(negedge clk); wfe = 1'b1;      @(negedge clk); wfe = 1'b0;      endtask
    task automatic pulse_wake(); @(negedge clk); wake_req = 1'b1; @(negedge clk); wake_req = 1'b0; endtask
    task automatic pulse_done(); @(negedge clk); seq_done = 1'b1; @(negedge clk); seq_done = 1'b0; endtask

    initial begin
        idle(3);
        rst = 1'b0;
        // R1 reset state
        rd(1, 0, "R1 mode status");
        rd(3, 0, "R1 sp status");
        rd(8, 'hFFFF, "R1 run mask");
        rd(4, 0, "R1 irq word");
        chk("R1 seq_req", int'(seq_req), 0);

        wr(4, 7);
        wr(8, 'h00FF);
        wr(9, 'h000F);
        rd(9, 'h000F, "R11 wait mask");

        // R5 / R6 allowed software request
        wr(2, (5 << 4) | 1);
        rd(2, (5 << 4) | 1, "R5 go held");
        chk("R5 seq_sp", int'(seq_sp), 5);
        idle(3);
        pulse_done();
        idle(1);
        rd(3, 'h505, "R6 R13 sp status");
        rd(2, 'h50, "R6 go cleared");
        pulse_done();
        idle(1);
        rd(3, 'h505, "R6 idle done ignored");

        // R7 refused software request
        wr(2, (9 << 4) | 1);
        idle(2);
        rd(4, 'h40007, "R7 sw status");
        rd(2, 'h90, "R7 go dropped");
        rd(3, 'h505, "R7 sp unchanged");
        chk("R10 irq raised", int'(irq), 1);
        wr(4, (1 << 18) | 7);
        idle(1);
        chk("R10 irq cleared", int'(irq), 0);
        rd(4, 7, "R10 w1c");

        // R11 lock
        wr(5, 1);
        wr(8, 'hFFFF);
        rd(8, 'h00FF, "R11 locked mask");
        wr(5, 0);
        rd(5, 1, "R11 lock sticky");

        // R3 / R2 WFE gating
        wr(0, 2);
        pulse_wfe();
        idle(1);
        rd(1, 0, "R3 wfe ignored");
        wr(0, 'h12);
        pulse_wfe();
        idle(1);
        rd(1, 2, "R2 enter stop");
        pulse_wake();
        idle(1);
        rd(1, 8, "R4 wake from stop");

        // R8 / R9 allowed sleep and saved-setpoint wakeup
        wr(2, (1 << 8) | (3 << 12) | (1 << 16) | (7 << 20));
        wr(0, 'h11);
        pulse_wfi();
        idle(1);
        rd(1, 1, "R8 in wait");
        chk("R8 seq_sp", int'(seq_sp), 3);
        rd(2, 'h713000, "R8 sleep go consumed");
        pulse_done();
        idle(1);
        rd(3, 'h353, "R8 sp status");
        pulse_wake();
        idle(1);
        chk("R9 seq_sp saved", int'(seq_sp), 5);
        pulse_done();
        idle(1);
        rd(3, 'h535, "R9 sp status");

        // R9 refused wakeup
        wr(2, (1 << 16) | (12 << 20) | (1 << 24));
        pulse_wfi();
        idle(1);
        pulse_wake();
        idle(2);
        rd(4, 'h20007, "R9 wake not allowed");
        rd(3, 'h535, "R9 sp unchanged");
        wr(4, (1 << 17) | 7);

        // R8 refused sleep
        wr(2, (1 << 8) | (8 << 12));
        pulse_wfi();
        idle(2);
        rd(4, 'h10007, "R8 sleep not allowed");
        chk("R8 no seq_req", int'(seq_req), 0);
        pulse_wake();
        wr(4, (1 << 16) | 7);

        // R12 sleep held off during a transition
        wr(2, (2 << 4) | 1);
        idle(2);
        wfi = 1'b1;
        idle(3);
        chk("R12 held in run", int'(cpu_mode), 0);
        pulse_done();
        idle(1);
        chk("R12 enter after done", int'(cpu_mode), 1);
        wfi = 1'b0;
        pulse_wake();
        idle(1);

        // R2 run target ignores sleep event
        wr(0, 'h10);
        pulse_wfi();
        idle(1);
        rd(1, 4, "R2 target run ignored");
        idle(2);

        ended = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule